// File: doc/BRIEF.md
# Supply-Guarded Byte Bus Front End

This block sits between a parallel byte bus and two storage back ends: a plain byte array and a small bank of clock and calendar registers. The bus side carries a 13-bit address, separate input and output data buses (with an output-drive flag standing in for the tristate pins), and four select strobes. The low strobes are chip select, output enable and write enable. The high strobe is a second chip select. Each qualified access is steered to one of the two back ends. The block offers both back ends a single-cycle strobe with a shared write-data bus and a combinational read-data return.

A digital supply-good flag comes from an external comparator. While that flag is low, every access is refused in the same cycle. Once the flag returns, access stays locked out for a programmable number of clock cycles so that the system can settle. An active-low reset output tells the rest of the system when the lockout is in force.

The bus is a plain strobe interface with no valid/ready handshake. A cycle is either taken or refused, and no access is ever held back for later.

Top module: `pgate_mem_port`

## Requirements
- R1: Addresses 0x1FF8 through 0x1FFF go to the clock register port, which sees the index in `rtc_sel` (address bits 2..0). Every lower address, including 0x1FF7, goes to the array port with the full address. A single access never strobes both ports.
- R2: An access happens only when `ce_n` is 0 and `ce2` is 1. If `ce_n` is 1 or `ce2` is 0, neither port is written and `dout_en` stays 0.
- R3: On an enabled cycle with `we_n` = 0, the selected port is written with `din`, whatever `oe_n` is. `dout_en` stays 0 during that cycle.
- R4: On an enabled cycle with `oe_n` = 0 and `we_n` = 1, `dout_en` is 1 and `dout` carries the selected port's read data. If `oe_n` is 1, `dout_en` is 0 and `dout` is 0.
- R5: While `pwr_ok` is 0, no write strobe or read drive occurs, starting in the same cycle that `pwr_ok` falls. `por_n` is 0 from the next rising edge onward.
- R6: After `pwr_ok` returns to 1, `por_n` rises on exactly the REC_CYCLES-th rising edge that samples `pwr_ok` high. Until then every access is refused.
- R7: If `pwr_ok` drops for any cycle during the lockout, the count restarts, and REC_CYCLES further high edges are needed.
- R8: While `rst_n` is 0, `por_n` is 0 and no access is taken. Release from reset starts a full lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| pwr_ok | input | 1 | Supply within tolerance, from an external comparator |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus (0 when not driven) |
| dout_en | output | 1 | Bus output driver enable |
| ce_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Second chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| por_n | output | 1 | Reset to the system, low during supply fault and lockout |
| ram_addr | output | 13 | Array port address |
| ram_wr | output | 1 | Array port write strobe |
| ram_rdata | input | 8 | Array port read data |
| rtc_sel | output | 3 | Clock register index |
| rtc_wr | output | 1 | Clock register write strobe |
| rtc_rdata | input | 8 | Clock register read data |
| st_wdata | output | 8 | Write data shared by both ports |

## Verification
A bus write and a supply failure can fall in the same cycle. The bench provokes this by lowering `pwr_ok` in the very cycle it presents a full write to the array. It then judges that no write strobe appears in that cycle, that `por_n` falls at the next edge, and that a later read of the same location returns the old byte. A second collision is a write with `oe_n` also low, where the write must win and the bus must stay undriven. Lockout length is judged by counting edges from each supply return, both after a clean return and after a one-cycle glitch partway through the lockout.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  typedef enum logic {
    TGT_ARRAY = 1'b0,
    TGT_CLOCK = 1'b1
  } tgt_e;

  typedef struct packed {
    logic wr_array;
    logic wr_clock;
    logic drive;
  } strobe_t;
endpackage

// File: rtl/pgate_supply_guard.sv
module pgate_supply_guard #(
  parameter int REC_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic chip_sel,
  output logic acc_en,
  output logic por_n
);
  localparam int CNT_W = $clog2(REC_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      open_q <= 1'b0;
    end else if (!pwr_ok) begin
      cnt    <= '0;
      open_q <= 1'b0;
    end else if (!open_q) begin
      if (cnt == LAST) open_q <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  // supply flag gates combinationally so a fault blocks in its own cycle
  assign acc_en = open_q & pwr_ok & chip_sel;
  assign por_n  = open_q;

  assert_por_low_after_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !por_n);

  assert_open_needs_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_n) |-> $past(pwr_ok));

  assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(REC_CYCLES));
endmodule

// File: rtl/pgate_decode.sv
module pgate_decode
  import pgate_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int CLK_REGS = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              acc_en,
  input  logic              oe_n,
  input  logic              we_n,
  output tgt_e              tgt,
  output strobe_t           stb
);
  localparam int SEL_W = $clog2(CLK_REGS);

  logic in_top;

  generate
    if (SEL_W >= ADDR_W) begin : g_all_clock
      assign in_top = 1'b1;
    end else begin : g_top_window
      assign in_top = &addr[ADDR_W-1:SEL_W];
    end
  endgenerate

  always_comb begin
    tgt          = in_top ? TGT_CLOCK : TGT_ARRAY;
    stb.wr_array = acc_en & ~we_n & (tgt == TGT_ARRAY);
    stb.wr_clock = acc_en & ~we_n & (tgt == TGT_CLOCK);
    stb.drive    = acc_en & we_n & ~oe_n;
  end
endmodule

// File: rtl/pgate_mem_port.sv
module pgate_mem_port
  import pgate_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int CLK_REGS   = 8,
  parameter int REC_CYCLES = 1000,
  localparam int SEL_W     = $clog2(CLK_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  input  logic              ce_n,
  input  logic              ce2,
  input  logic              oe_n,
  input  logic              we_n,
  output logic              por_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_wr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [SEL_W-1:0]  rtc_sel,
  output logic              rtc_wr,
  input  logic [DATA_W-1:0] rtc_rdata,
  output logic [DATA_W-1:0] st_wdata
);
  logic    acc_en;
  tgt_e    tgt;
  strobe_t stb;

  pgate_supply_guard #(.REC_CYCLES(REC_CYCLES)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_ok   (pwr_ok),
    .chip_sel (~ce_n & ce2),
    .acc_en   (acc_en),
    .por_n    (por_n)
  );

  pgate_decode #(.ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS)) u_dec (
    .addr   (addr),
    .acc_en (acc_en),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .tgt    (tgt),
    .stb    (stb)
  );

  assign ram_addr = addr;
  assign rtc_sel  = addr[SEL_W-1:0];
  assign st_wdata = din;
  assign ram_wr   = stb.wr_array;
  assign rtc_wr   = stb.wr_clock;
  assign dout_en  = stb.drive;

  always_comb begin
    if (!stb.drive)            dout = '0;
    else if (tgt == TGT_CLOCK) dout = rtc_rdata;
    else                       dout = ram_rdata;
  end

  assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_wr && rtc_wr));

  assert_chip_select_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || !ce2) |-> !(ram_wr || rtc_wr || dout_en));

  assert_write_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dout_en);

  assert_supply_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !(ram_wr || rtc_wr || dout_en));

  assert_lockout_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !por_n |-> !(ram_wr || rtc_wr || dout_en));
endmodule

// File: tb/pgate_mem_port_bench.sv
`timescale 1ns/1ps
module pgate_mem_port_bench;
  localparam int REC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en;
  logic ce_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic por_n;
  logic [12:0] ram_addr;
  logic ram_wr;
  logic [7:0] ram_rdata;
  logic [2:0] rtc_sel;
  logic rtc_wr;
  logic [7:0] rtc_rdata;
  logic [7:0] st_wdata;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pgate_mem_port #(.REC_CYCLES(REC)) u_pgate_mem_port (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .ce_n(ce_n), .ce2(ce2), .oe_n(oe_n),
    .we_n(we_n), .por_n(por_n), .ram_addr(ram_addr), .ram_wr(ram_wr),
    .ram_rdata(ram_rdata), .rtc_sel(rtc_sel), .rtc_wr(rtc_wr),
    .rtc_rdata(rtc_rdata), .st_wdata(st_wdata)
  );

  // back-end models: array indexed by the low address byte, 8 clock registers
  logic [7:0] mem [0:255];
  logic [7:0] rtcm [0:7];
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) rtcm[i] = 8'h00;
  end
  always @(posedge clk) begin
    if (ram_wr) mem[ram_addr[7:0]] <= st_wdata;
    if (rtc_wr) rtcm[rtc_sel] <= st_wdata;
  end
  assign ram_rdata = mem[ram_addr[7:0]];
  assign rtc_rdata = rtcm[rtc_sel];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard of expected read bytes
  logic [7:0] exp_q[$];
  string tag_q[$];

  always @(negedge clk) begin
    if (dout_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected drive", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(dout == e, t, dout, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle();
    ce_n = 1'b1; ce2 = 1'b0; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic drive(input logic [12:0] a, input logic [7:0] d,
                       input logic cn, input logic c2, input logic oe, input logic we);
    step();
    addr = a; din = d; ce_n = cn; ce2 = c2; oe_n = oe; we_n = we;
    #1;
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [7:0] d, input string tag);
    bit clk_tgt;
    clk_tgt = (a >= 13'h1FF8);
    drive(a, d, 1'b0, 1'b1, 1'b1, 1'b0);
    chk(ram_wr == !clk_tgt && rtc_wr == clk_tgt, tag, {ram_wr, rtc_wr}, {!clk_tgt, clk_tgt});
    if (clk_tgt) chk(rtc_sel == a[2:0], tag, rtc_sel, a[2:0]);
    else         chk(ram_addr == a, tag, ram_addr, a);
    step(); idle();
  endtask

  task automatic bus_read(input logic [12:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    drive(a, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    chk(dout_en == 1'b1, tag, dout_en, 1);
    step(); idle();
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic count_open(input string tag);
    int n;
    n = 0;
    while (!por_n && n < 200) begin step(); n++; end
    chk(n == REC, tag, n, REC);
  endtask

  initial begin
    #800000;
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1;
    // R8: reset state
    chk(por_n == 1'b0, "R8 por_n in reset", por_n, 0);
    addr = 13'h0010; ce_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; #1;
    chk(ram_wr == 1'b0, "R8 no write in reset", ram_wr, 0);
    idle();
    repeat (3) step();
    rst_n = 1'b1;
    count_open("R8 R6 lockout after reset");

    // R1 R3 R4: array writes and reads, several patterns
    bus_write(13'h0012, 8'hA5, "R1 array write 0012");
    bus_write(13'h0A34, 8'h5A, "R1 array write 0A34");
    bus_write(13'h1FF7, 8'hC3, "R1 boundary 1FF7 to array");
    bus_read(13'h0012, 8'hA5, "R4 read 0012");
    bus_read(13'h0A34, 8'h5A, "R4 read 0A34");
    bus_read(13'h1FF7, 8'hC3, "R4 read 1FF7");

    // R1: clock window, every register
    for (int i = 0; i < 8; i++) bus_write(13'h1FF8 + 13'(i), 8'(8'h30 + i), "R1 clock write");
    for (int i = 0; i < 8; i++) bus_read(13'h1FF8 + 13'(i), 8'(8'h30 + i), "R1 clock read");
    bus_read(13'h1FF7, 8'hC3, "R1 clock writes left array alone");

    // R2: chip selects
    drive(13'h0012, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0);
    chk(ram_wr == 1'b0, "R2 ce_n high blocks write", ram_wr, 0);
    drive(13'h0012, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(dout_en == 1'b0, "R2 ce2 low blocks read", dout_en, 0);
    drive(13'h1FF9, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(rtc_wr == 1'b0, "R2 ce2 low blocks clock write", rtc_wr, 0);
    step(); idle();
    bus_read(13'h0012, 8'hA5, "R2 array unchanged");
    bus_read(13'h1FF9, 8'h31, "R2 clock reg unchanged");

    // R3: write with oe_n also low
    drive(13'h155C, 8'h7E, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(ram_wr == 1'b1 && dout_en == 1'b0, "R3 write wins over oe", {ram_wr, dout_en}, 2'b10);
    step(); idle();
    bus_read(13'h155C, 8'h7E, "R3 write stored");

    // R4: oe_n high, no drive
    drive(13'h155C, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    chk(dout_en == 1'b0 && dout == 8'h00, "R4 oe high no drive", {dout_en, dout}, 0);
    step(); idle();

    // R5: fault in the same cycle as a write
    step();
    addr = 13'h0012; din = 8'h11; ce_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; pwr_ok = 1'b0;
    #1;
    chk(ram_wr == 1'b0, "R5 same-cycle fault blocks write", ram_wr, 0);
    step(); idle();
    chk(por_n == 1'b0, "R5 por_n low after fault", por_n, 0);

    // R6: lockout after clean return
    pwr_ok = 1'b1;
    repeat (REC - 1) step();
    chk(por_n == 1'b0, "R6 still locked one edge early", por_n, 0);
    addr = 13'h0012; din = 8'h22; ce_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; #1;
    chk(ram_wr == 1'b0, "R6 access refused in lockout", ram_wr, 0);
    step(); idle();
    chk(por_n == 1'b1, "R6 opens after REC edges", por_n, 1);
    bus_read(13'h0012, 8'hA5, "R5 R6 blocked writes left data");

    // R7: glitch restarts the count
    pwr_ok = 1'b0;
    step();
    pwr_ok = 1'b1;
    repeat (5) step();
    pwr_ok = 1'b0;
    step();
    pwr_ok = 1'b1;
    chk(por_n == 1'b0, "R7 locked after glitch", por_n, 0);
    count_open("R7 full count after glitch");
    bus_write(13'h0A34, 8'h99, "R7 access after reopen");
    bus_read(13'h0A34, 8'h99, "R7 read after reopen");

    repeat (2) step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule